// File: doc/BRIEF.md
# One-Wire Search ROM Accelerator

This block sits on the master side of a one-wire bus and runs the ROM search tree in hardware, one byte at a time. Software first issues a bus reset and sends the search command byte 0xF0 in ordinary byte mode. It then turns on accelerator mode and exchanges 16 bytes. Each byte covers four ROM bit positions, so the 16 bytes cover all 64 positions.

For every position the block requests three bus slots. It reads the true bit, then reads the complement bit, then writes the direction it has resolved. The direction to use on a conflict comes from the odd bits of the byte that software wrote. The byte returned to software interleaves a discrepancy flag and the selected ROM bit for each position. A transmit-done status bit, which can raise the interrupt, marks the end of every byte.

Bus waveform timing is kept outside the block. A slot engine receives a slot request together with the bit to drive, and answers with a done pulse and the bit it sampled on the bus.

Top module: `owsa_search_accel`

## Requirements
- R1: In accelerator mode a data write exchanges four positions, with position k placed at result bits 2k (discrepancy flag) and 2k+1 (selected ROM bit), lowest position first. Each position uses three slots in this order: read true (drive 1), read complement (drive 1), write the selected bit. A byte without a void position therefore uses exactly 12 slots.
- R2: When the true and complement bits differ, the block writes the true bit and returns the pair {rom=true, flag=0}.
- R3: When both bits read 0, the block writes the direction bit, taken from bit 2k+1 of the written byte, and returns {rom=direction, flag=1}.
- R4: When both bits read 1, no device answered. Result bits from 2k upward are all set to 1, the write slot for position k is skipped, and the byte ends right after that complement slot.
- R5: With accelerator mode off, a data write runs 8 slots. Slot i drives bit i of the written byte (least significant bit first), and result bit i is the bit sampled in slot i.
- R6: The command register sits at offset 0x04. Writing 0x02 (bit 1 set) enables accelerator mode, and writing 0x00 disables it. A read returns 0x02 when the mode is on and 0x00 when it is off.
- R7: The end of every byte sets bit 4 (mask 0x10) of the status register at offset 0x0A. The irq output is high while that bit is set and bit 4 of the enable register at offset 0x0C is set.
- R8: A read strobe on the data register (offset 0x08) returns the last completed byte and clears status bit 4. It starts no transfer. A read of the status register does not clear the bit.
- R9: A data write that arrives while a byte is in progress is ignored.
- R10: slot_req stays high, with slot_wbit held steady, until slot_done arrives. slot_req then drops for at least one cycle before the next slot.
- R11: After reset, every register reads 0, and irq and slot_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has side effects on data) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq | output | 1 | Transmit-done interrupt |
| slot_req | output | 1 | Slot request to the bus timing engine |
| slot_wbit | output | 1 | Bit to drive during the requested slot |
| slot_done | input | 1 | One-cycle completion of the current slot |
| slot_rbit | input | 1 | Bus level sampled in the completed slot, valid with slot_done |

## Verification
Accelerator bytes are run with true/complement patterns chosen one at a time so that each resolution case can be seen on its own: all positions distinct, all conflicts with direction 0, all conflicts with direction 1, a mixture, and void positions at the first and at the third position. Comparing the slot count and the bits written in the write slots separates a skipped write slot from a wrong pair encoding. Ordinary byte mode is run with wired-AND bus patterns, so that a reversed bit order or a swap between sampled and driven bits shows up in the result. Directed steps cover the interrupt gating, the clearing rule, a data write made while busy, and the reset values.

// File: rtl/owsa_pkg.sv
package owsa_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SLOT, ST_GAP} seq_st_e;
  typedef enum logic [1:0] {PH_TRUE, PH_COMP, PH_DRIVE} phase_e;

  // pair result {rom_bit, flag} for one ROM position
  function automatic logic [1:0] resolve_pair(input logic t_bit, input logic c_bit,
                                              input logic dir_bit);
    logic [1:0] r;
    if (t_bit != c_bit)  r = {t_bit, 1'b0};
    else if (!t_bit)     r = {dir_bit, 1'b1};
    else                 r = 2'b11;
    return r;
  endfunction

  function automatic logic pair_void(input logic t_bit, input logic c_bit);
    return t_bit & c_bit;
  endfunction

endpackage

// File: rtl/owsa_pair.sv
module owsa_pair
  import owsa_pkg::*;
(
  input  logic       t_bit,
  input  logic       c_bit,
  input  logic       dir_bit,
  output logic [1:0] pair_bits,
  output logic       no_answer
);
  always_comb begin
    pair_bits = resolve_pair(t_bit, c_bit, dir_bit);
    no_answer = pair_void(t_bit, c_bit);
  end
endmodule

// File: rtl/owsa_seq.sv
module owsa_seq
  import owsa_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              accel,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              slot_req,
  output logic              slot_wbit,
  input  logic              slot_done,
  input  logic              slot_rbit,
  output logic              busy,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int PAIRS    = BYTE_W / 2;
  localparam int POS_W    = $clog2(BYTE_W);
  localparam int SLOT_MAX = 3 * PAIRS;
  localparam int CNT_W    = $clog2(SLOT_MAX + BYTE_W + 1);

  seq_st_e           st_q;
  phase_e            ph_q;
  logic              acc_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] rx_q;
  logic [POS_W-1:0]  pos_q;
  logic              t_q;
  logic              drv_q;
  logic              done_q;

  // named internal events
  logic       slot_fire;
  logic       dir_bit;
  logic [1:0] pair_bits;
  logic       no_answer;
  logic       last_norm;
  logic       last_acc;

  function automatic logic [BYTE_W-1:0] upper_mask(input logic [POS_W-1:0] p);
    logic [BYTE_W-1:0] m;
    for (int i = 0; i < BYTE_W; i++) m[i] = (i >= 2 * int'(p));
    return m;
  endfunction

  assign slot_fire = (st_q == ST_SLOT) && slot_done;
  assign dir_bit   = tx_q[{pos_q[POS_W-2:0], 1'b1}];
  assign last_norm = (pos_q == POS_W'(BYTE_W - 1));
  assign last_acc  = (pos_q == POS_W'(PAIRS - 1));

  owsa_pair u_pair (
    .t_bit     (t_q),
    .c_bit     (slot_rbit),
    .dir_bit   (dir_bit),
    .pair_bits (pair_bits),
    .no_answer (no_answer)
  );

  assign slot_req  = (st_q == ST_SLOT);
  assign slot_wbit = !acc_q ? tx_q[pos_q] : ((ph_q == PH_DRIVE) ? drv_q : 1'b1);
  assign busy      = (st_q != ST_IDLE);
  assign byte_done = done_q;
  assign rx_byte   = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_TRUE;
      acc_q  <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      pos_q  <= '0;
      t_q    <= 1'b0;
      drv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            acc_q <= accel;
            tx_q  <= tx_byte;
            rx_q  <= '0;
            pos_q <= '0;
            ph_q  <= PH_TRUE;
            st_q  <= ST_SLOT;
          end
        end
        ST_SLOT: begin
          if (slot_done) begin
            if (!acc_q) begin
              rx_q[pos_q] <= slot_rbit;
              if (last_norm) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                pos_q <= pos_q + 1'b1;
                st_q  <= ST_GAP;
              end
            end else begin
              case (ph_q)
                PH_TRUE: begin
                  t_q  <= slot_rbit;
                  ph_q <= PH_COMP;
                  st_q <= ST_GAP;
                end
                PH_COMP: begin
                  if (no_answer) begin
                    rx_q   <= rx_q | upper_mask(pos_q);
                    ph_q   <= PH_TRUE;
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                  end else begin
                    rx_q[{pos_q[POS_W-2:0], 1'b0} +: 2] <= pair_bits;
                    drv_q <= pair_bits[1];
                    ph_q  <= PH_DRIVE;
                    st_q  <= ST_GAP;
                  end
                end
                default: begin
                  ph_q <= PH_TRUE;
                  if (last_acc) begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                  end else begin
                    pos_q <= pos_q + 1'b1;
                    st_q  <= ST_GAP;
                  end
                end
              endcase
            end
          end
        end
        default: st_q <= ST_SLOT;
      endcase
    end
  end

  // slot budget tracked for the checks below
  logic [CNT_W-1:0] n_slots;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      n_slots <= '0;
    else if (start && !busy)         n_slots <= '0;
    else if (slot_fire)              n_slots <= n_slots + 1'b1;
  end

  // R10: request drops after every completion
  p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    slot_fire |=> !slot_req);

  // R10: request and drive bit hold until completion
  p_wbit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_done) |=> (slot_req && $stable(slot_wbit)));

  // R1: an accelerator byte never exceeds three slots per position
  p_acc_budget_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && acc_q) |-> (n_slots <= CNT_W'(SLOT_MAX)));

  // R5: an ordinary byte is exactly one slot per bit
  p_norm_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !acc_q) |-> (n_slots == CNT_W'(BYTE_W)));

  // R9: completion always returns the sequencer to idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !busy);

endmodule

// File: rtl/owsa_regs.sv
module owsa_regs #(
  parameter int          ADDR_W   = 4,
  parameter int          BYTE_W   = 8,
  parameter logic [3:0]  OFS_CMD  = 4'h4,
  parameter logic [3:0]  OFS_DATA = 4'h8,
  parameter logic [3:0]  OFS_STAT = 4'hA,
  parameter logic [3:0]  OFS_IEN  = 4'hC,
  parameter int          DONE_BIT = 4,
  parameter int          ACC_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              start,
  output logic              accel,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  logic              acc_q;
  logic              ien_q;
  logic              stat_q;
  logic [BYTE_W-1:0] rxh_q;

  logic sel_cmd, sel_data, sel_stat, sel_ien;
  logic data_rd;

  assign sel_cmd  = (reg_addr == ADDR_W'(OFS_CMD));
  assign sel_data = (reg_addr == ADDR_W'(OFS_DATA));
  assign sel_stat = (reg_addr == ADDR_W'(OFS_STAT));
  assign sel_ien  = (reg_addr == ADDR_W'(OFS_IEN));
  assign data_rd  = reg_rd && sel_data;

  assign start   = reg_wr && sel_data && !busy;
  assign accel   = acc_q;
  assign tx_byte = reg_wdata;
  assign irq     = stat_q & ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      ien_q  <= 1'b0;
      stat_q <= 1'b0;
      rxh_q  <= '0;
    end else begin
      if (reg_wr && sel_cmd) acc_q <= reg_wdata[ACC_BIT];
      if (reg_wr && sel_ien) ien_q <= reg_wdata[DONE_BIT];
      if (byte_done) begin
        stat_q <= 1'b1;
        rxh_q  <= rx_byte;
      end else if (data_rd) begin
        stat_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_cmd)  reg_rdata[ACC_BIT]  = acc_q;
    if (sel_data) reg_rdata           = rxh_q;
    if (sel_stat) reg_rdata[DONE_BIT] = stat_q;
    if (sel_ien)  reg_rdata[DONE_BIT] = ien_q;
  end

  // R7: completion sets the status bit
  p_stat_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> stat_q);

  // R8: a data read with no completion clears the status bit
  p_stat_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !byte_done) |=> !stat_q);

  // R8: reading the status register leaves the bit in place
  p_stat_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel_stat && stat_q) |=> stat_q);

endmodule

// File: rtl/owsa_search_accel.sv
module owsa_search_accel #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  output logic              slot_req,
  output logic              slot_wbit,
  input  logic              slot_done,
  input  logic              slot_rbit
);
  logic              start;
  logic              accel;
  logic [BYTE_W-1:0] tx_byte;
  logic              busy;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;

  owsa_regs #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .start     (start),
    .accel     (accel),
    .tx_byte   (tx_byte),
    .irq       (irq)
  );

  owsa_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accel     (accel),
    .tx_byte   (tx_byte),
    .slot_req  (slot_req),
    .slot_wbit (slot_wbit),
    .slot_done (slot_done),
    .slot_rbit (slot_rbit),
    .busy      (busy),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  // R11: nothing is requested or signalled straight out of reset
  p_reset_quiet_r11: assert property (@(posedge clk)
    $rose(rst_n) |-> (!slot_req && !irq));

endmodule

// File: tb/test_owsa_search_accel.sv
module test_owsa_search_accel;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CMD = 4'h4, A_DATA = 4'h8, A_STAT = 4'hA, A_IEN = 4'hC;

  // {acc, tx, bus pattern, exp rx, exp slots, exp drive bits}
  localparam logic [47:0] VEC [8] = '{
    {8'h01, 8'h00, 8'h99, 8'h22, 8'h0C, 8'h05},  // R1 R2 all distinct
    {8'h01, 8'hAA, 8'h00, 8'hFF, 8'h0C, 8'h0F},  // R3 conflicts, direction 1
    {8'h01, 8'h00, 8'h00, 8'h55, 8'h0C, 8'h00},  // R3 conflicts, direction 0
    {8'h01, 8'h88, 8'h60, 8'h8D, 8'h0C, 8'h0A},  // R1 R2 R3 mixed
    {8'h01, 8'h00, 8'h39, 8'hF2, 8'h08, 8'h01},  // R4 void at position 2
    {8'h01, 8'h00, 8'h03, 8'hFF, 8'h02, 8'h00},  // R4 void at position 0
    {8'h00, 8'hFF, 8'h5A, 8'h5A, 8'h08, 8'hFF},  // R5 ordinary byte
    {8'h00, 8'h3C, 8'hF0, 8'h30, 8'h08, 8'h3C}   // R5 ordinary byte
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, slot_req, slot_wbit;
  logic slot_done = 1'b0, slot_rbit = 1'b0;

  logic [15:0] rvec = '1;
  logic [15:0] wlog = '0;
  int sidx = 0;
  int n_checks = 0, n_fail = 0;
  logic eb, ew;

  always #(CLK_PERIOD/2) clk = ~clk;

  owsa_search_accel i_owsa_search_accel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .slot_req(slot_req), .slot_wbit(slot_wbit),
    .slot_done(slot_done), .slot_rbit(slot_rbit)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // slot engine: wired-AND bus, answers two cycles after a request
  initial begin
    forever begin
      @(negedge clk);
      if (slot_req) begin
        ew = slot_wbit;
        if (sidx < 16) wlog[sidx] = ew;
        eb = (sidx < 16) ? (rvec[sidx] & ew) : ew;
        repeat (2) @(negedge clk);
        check("R10 request held with steady drive bit", {slot_req, slot_wbit}, {1'b1, ew});
        slot_rbit = eb;
        slot_done = 1'b1;
        @(negedge clk);
        slot_done = 1'b0;
        sidx++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done;
    logic [7:0] s;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      peek(A_STAT, s);
      if (s[4]) return;
    end
    check("R7 completion seen", 0, 1);
  endtask

  task automatic load_bus(input logic acc, input logic [7:0] pat);
    rvec = '1;
    if (acc) begin
      for (int k = 0; k < 4; k++) begin
        rvec[3*k]   = pat[2*k];
        rvec[3*k+1] = pat[2*k+1];
      end
    end else begin
      rvec[7:0] = pat;
    end
    wlog = '0;
    sidx = 0;
  endtask

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    peek(A_CMD, v);  check("R11 command after reset", v, 8'h00);
    peek(A_DATA, v); check("R11 data after reset", v, 8'h00);
    peek(A_STAT, v); check("R11 status after reset", v, 8'h00);
    peek(A_IEN, v);  check("R11 enable after reset", v, 8'h00);
    check("R11 irq and request low", {irq, slot_req}, 2'b00);

    // R6 mode register
    reg_write(A_CMD, 8'h02); peek(A_CMD, v); check("R6 mode on", v, 8'h02);
    reg_write(A_CMD, 8'h00); peek(A_CMD, v); check("R6 mode off", v, 8'h00);

    // vector table
    for (int n = 0; n < 8; n++) begin
      logic [47:0] e;
      logic [7:0] obs;
      e = VEC[n];
      reg_write(A_CMD, e[40] ? 8'h02 : 8'h00);
      reg_write(A_IEN, 8'h10);
      load_bus(e[40], e[31:24]);
      reg_write(A_DATA, e[39:32]);
      wait_done();
      check("R7 irq on completion", irq, 1);
      reg_read(A_DATA, v);
      check(e[40] ? "R1 R2 R3 R4 result byte" : "R5 result byte", v, e[23:16]);
      check(e[40] ? "R1 R4 slot count" : "R5 slot count", sidx, e[15:8]);
      obs = '0;
      if (e[40]) begin
        for (int k = 0; k < 4; k++)
          if (3*k+2 < sidx) obs[k] = wlog[3*k+2];
      end else begin
        obs = wlog[7:0];
      end
      check(e[40] ? "R2 R3 written direction bits" : "R5 driven bits", obs, e[7:0]);
      peek(A_STAT, v);
      check("R8 status cleared by data read", v, 8'h00);
      check("R8 irq low after data read", irq, 0);
    end

    // R7 gating by the enable bit
    reg_write(A_CMD, 8'h00);
    reg_write(A_IEN, 8'h00);
    load_bus(1'b0, 8'hC3);
    reg_write(A_DATA, 8'hFF);
    wait_done();
    repeat (2) @(negedge clk);
    check("R7 irq held off while disabled", irq, 0);
    reg_write(A_IEN, 8'h10);
    #1 check("R7 irq once enabled", irq, 1);

    // R8 status read keeps the bit; data read starts nothing
    reg_read(A_STAT, v);
    peek(A_STAT, v);
    check("R8 status read does not clear", v, 8'h10);
    reg_read(A_DATA, v);
    check("R8 data read value", v, 8'hC3);
    repeat (20) @(negedge clk);
    check("R8 data read starts no slot", sidx, 8);

    // R9 data write while busy is ignored
    load_bus(1'b0, 8'h0F);
    reg_write(A_DATA, 8'hFF);
    reg_write(A_DATA, 8'h00);
    wait_done();
    repeat (40) @(negedge clk);
    check("R9 busy write adds no slots", sidx, 8);
    reg_read(A_DATA, v);
    check("R9 result from first write", v, 8'h0F);

    summary();
  end
endmodule